// File: doc/BRIEF.md
# Two-cycle ready-latency packet transmitter

This block takes packet beats from an application source and presents them on a 64-bit streaming transmit interface. Each beat on that interface carries data, a start-of-packet flag and an end-of-packet flag. Valid on that interface is qualified by a ready signal that takes effect two clock cycles late. The sink may drop ready at any time. The block then removes valid exactly two cycles later. The pending beat stays frozen on the bus until the re-asserted ready has worked its way through the two-cycle delay. While ready is held high, consecutive packets go out with the first beat of one packet directly after the last beat of the one before.

Beats from the source enter a small buffer through a plain same-cycle valid/ready handshake. As each beat enters, a per-packet rule is applied to it. When end-to-end CRC forwarding is enabled, Type 0 configuration requests must not claim a digest. For these packets the digest-present bit of the first header doubleword is forced to zero. Every other beat passes through untouched. The block does not compute the CRC itself.

Top module: `tlp_tx_rl2`

## Requirements
- R1: While rst_ni is low, tx_valid_o, tx_sop_o and tx_eop_o are low. The ready history restarts as not-ready, so in the first cycle after reset is released tx_valid_o stays low whatever tx_ready_i was.
- R2: tx_valid_o is high only in a cycle where tx_ready_i was high two cycles earlier, as sampled at the rising clock edges. In every such cycle with a buffered beat, tx_valid_o is high.
- R3: When tx_ready_i is low in a cycle, tx_valid_o is low two cycles later. No beat is transferred in that cycle.
- R4: While a beat is buffered but not transferred, tx_data_o, tx_sop_o and tx_eop_o hold their values until the cycle in which it is transferred.
- R5: With tx_ready_i held high and beats available, the start beat of a packet is transferred in the cycle right after the end beat of the previous packet.
- R6: A beat is transferred in every cycle where tx_valid_o is high. Every beat accepted from the source is transferred exactly once, in acceptance order, with its start/end flags intact.
- R7: src_ready_o is high whenever the buffer (DEPTH beats, default 4) has free space. A source beat is accepted on a rising edge where src_valid_i and src_ready_o are both high.
- R8: A start beat is a Type 0 configuration request when data bits [31:29] are 3'b000 or 3'b010 and bits [28:24] are 5'b00100. If ecrc_fwd_en_i is high when such a beat is accepted, its bit 15 is transmitted as 0 and all other bits are unchanged.
- R9: Other start beats, all non-start beats, and every beat accepted while ecrc_fwd_en_i is low are transmitted unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ecrc_fwd_en_i | input | 1 | Enables the digest-bit rule for configuration Type 0 packets |
| src_valid_i | input | 1 | Source beat valid |
| src_sop_i | input | 1 | Source beat is first of packet |
| src_eop_i | input | 1 | Source beat is last of packet |
| src_data_i | input | 64 | Source beat data |
| src_ready_o | output | 1 | Buffer can accept a beat |
| tx_ready_i | input | 1 | Sink ready, takes effect two cycles later |
| tx_valid_o | output | 1 | Transmit beat valid |
| tx_sop_o | output | 1 | Transmit beat is first of packet |
| tx_eop_o | output | 1 | Transmit beat is last of packet |
| tx_data_o | output | 64 | Transmit beat data |

## Verification
The framing property assumes that the source delivers well-formed packets. Each packet starts with a start beat, ends with an end beat, and no start beat appears inside an open packet. The stimulus builds every packet from this rule, and it puts look-alike configuration headers only on non-start beats. The latency properties assume the sink may toggle tx_ready_i freely, so the bench uses steady, periodic, random and long-stall ready patterns. The source side is driven with and without idle gaps so that the buffer both fills and runs empty.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned TD_BIT = 15;

  localparam logic [2:0] FMT_HDR3_NODATA = 3'b000;
  localparam logic [2:0] FMT_HDR3_DATA   = 3'b010;
  localparam logic [4:0] TYPE_CFG0       = 5'b00100;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [DATA_W-1:0] data;
  } beat_t;

  function automatic logic is_cfg0(input logic [31:0] dw0);
    logic fmt_ok;
    fmt_ok = (dw0[31:29] == FMT_HDR3_NODATA) || (dw0[31:29] == FMT_HDR3_DATA);
    return fmt_ok && (dw0[28:24] == TYPE_CFG0);
  endfunction
endpackage

// File: rtl/tlp_rdy_delay.sv
module tlp_rdy_delay #(
  parameter int unsigned LATENCY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic qual_o
);
  logic [LATENCY-1:0] hist_q;

  generate
    if (LATENCY == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= rdy_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[LATENCY-2:0], rdy_i};
      end
    end
  endgenerate

  assign qual_o = hist_q[LATENCY-1];
endmodule

// File: rtl/tlp_cfg0_td_filter.sv
module tlp_cfg0_td_filter
  import tlp_tx_pkg::*;
(
  input  logic  en_i,
  input  beat_t beat_i,
  output beat_t beat_o
);
  always_comb begin
    beat_o = beat_i;
    // only the header beat carries the digest-present bit
    if (en_i && beat_i.sop && is_cfg0(beat_i.data[31:0])) begin
      beat_o.data[TD_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/tlp_beat_fifo.sv
module tlp_beat_fifo
  import tlp_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  beat_t beat_i,
  input  logic  pop_i,
  output beat_t head_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  beat_t         mem_q [DEPTH];
  logic [AW-1:0] wr_idx_q, rd_idx_q;
  logic [AW:0]   count_q;
  logic          push_ok, pop_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_idx_q] <= beat_i;
        wr_idx_q        <= (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
      end
      if (pop_ok) begin
        rd_idx_q <= (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/tlp_tx_rl2.sv
module tlp_tx_rl2
  import tlp_tx_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned LATENCY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecrc_fwd_en_i,
  input  logic              src_valid_i,
  input  logic              src_sop_i,
  input  logic              src_eop_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic  rdy_qual;
  logic  fifo_empty, fifo_full;
  beat_t in_beat, flt_beat, head_beat;

  tlp_rdy_delay #(.LATENCY(LATENCY)) u_rdy_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (tx_ready_i),
    .qual_o (rdy_qual)
  );

  assign in_beat = '{sop: src_sop_i, eop: src_eop_i, data: src_data_i};

  tlp_cfg0_td_filter u_filter (
    .en_i   (ecrc_fwd_en_i),
    .beat_i (in_beat),
    .beat_o (flt_beat)
  );

  tlp_beat_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (src_valid_i),
    .beat_i  (flt_beat),
    .pop_i   (tx_valid_o),
    .head_o  (head_beat),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign src_ready_o = !fifo_full;
  assign tx_valid_o  = rdy_qual && !fifo_empty;
  // flags stay tied to the buffered head so they hold through a stall
  assign tx_sop_o    = head_beat.sop && !fifo_empty;
  assign tx_eop_o    = head_beat.eop && !fifo_empty;
  assign tx_data_o   = head_beat.data;
endmodule

// File: rtl/tlp_tx_rl2_chk.sv
module tlp_tx_rl2_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_ready_i,
  input logic        tx_valid_o,
  input logic        tx_sop_o,
  input logic        tx_eop_o,
  input logic [63:0] tx_data_o,
  input logic        src_ready_o,
  input logic        fifo_empty
);
  logic in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt_q <= 1'b0;
    else if (tx_valid_o) in_pkt_q <= !tx_eop_o;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_idle_r1: assert (!tx_valid_o && !tx_sop_o && !tx_eop_o);
    end
  end

  // checker written for the default two-cycle latency
  p_valid_qual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_ready_i, 2));

  p_drop_after_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_i |-> ##2 !tx_valid_o);

  p_hold_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_empty && !tx_valid_o) |=>
      ($stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o)));

  p_sop_outside_pkt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_sop_o) |-> !in_pkt_q);

  p_cont_inside_pkt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_sop_o) |-> in_pkt_q);

  p_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_ready_o |-> !fifo_empty);
endmodule

bind tlp_tx_rl2 tlp_tx_rl2_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_ready_i  (tx_ready_i),
  .tx_valid_o  (tx_valid_o),
  .tx_sop_o    (tx_sop_o),
  .tx_eop_o    (tx_eop_o),
  .tx_data_o   (tx_data_o),
  .src_ready_o (src_ready_o),
  .fifo_empty  (fifo_empty)
);

// File: tb/test_tlp_tx_rl2.sv
module test_tlp_tx_rl2;
  localparam int DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ecrc_fwd_en_i = 1'b0;
  logic        src_valid_i = 1'b0;
  logic        src_sop_i = 1'b0;
  logic        src_eop_i = 1'b0;
  logic [63:0] src_data_i = '0;
  logic        src_ready_o;
  logic        tx_ready_i = 1'b0;
  logic        tx_valid_o, tx_sop_o, tx_eop_o;
  logic [63:0] tx_data_o;

  tlp_tx_rl2 i_tlp_tx_rl2 (
    .clk_i, .rst_ni, .ecrc_fwd_en_i, .src_valid_i, .src_sop_i, .src_eop_i,
    .src_data_i, .src_ready_o, .tx_ready_i, .tx_valid_o, .tx_sop_o,
    .tx_eop_o, .tx_data_o
  );

  always #10 clk_i = ~clk_i;

  logic [65:0] stim_q[$];
  logic [65:0] exp_q[$];
  int  checks = 0, fails = 0, b2b = 0, cyc = 0;
  bit  h0 = 0, h1 = 0, prev_eop_xfer = 0;
  int  rdy_mode = 0, gap_mode = 0, en_req = 0, pat = 0;
  bit  done = 0;

  task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit cfg0_hdr(input logic [65:0] b);
    return b[65] && (b[28:24] == 5'b00100) && (b[31:29] == 3'b000 || b[31:29] == 3'b010);
  endfunction

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      h0 = 0; h1 = 0; prev_eop_xfer = 0;
      exp_q.delete();
    end else begin
      bit xv, acc;
      logic [65:0] b;
      xv  = h1 && (exp_q.size() > 0);
      acc = src_valid_i && (exp_q.size() < DEPTH);
      if (xv) begin
        b = exp_q.pop_front();
        if (b[65] && prev_eop_xfer) b2b++;
        prev_eop_xfer = b[64];
      end else begin
        prev_eop_xfer = 0;
      end
      if (acc) begin
        b = {src_sop_i, src_eop_i, src_data_i};
        if (ecrc_fwd_en_i && cfg0_hdr(b)) b[15] = 1'b0;
        exp_q.push_back(b);
        void'(stim_q.pop_front());
      end
      h1 = h0;
      h0 = tx_ready_i;
    end
  end

  // compare on falling edge, then drive next inputs
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit xv;
      string tag;
      xv = h1 && (exp_q.size() > 0);
      tag = (exp_q.size() == 0) ? "R6" : (h1 ? "R2" : "R3");
      chk(tag, {65'b0, tx_valid_o}, {65'b0, xv});
      chk("R7", {65'b0, src_ready_o}, {65'b0, exp_q.size() < DEPTH});
      if (exp_q.size() > 0) begin
        if (!xv) tag = "R4";
        else if (cfg0_hdr(exp_q[0])) tag = "R8";
        else tag = "R9";
        chk(tag, {tx_sop_o, tx_eop_o, tx_data_o}, exp_q[0]);
      end
    end
    pat = (pat + 1) % 5;
    case (rdy_mode)
      0: tx_ready_i <= 1'b1;
      1: tx_ready_i <= 1'b0;
      2: tx_ready_i <= 1'($urandom_range(0, 1));
      default: tx_ready_i <= (pat < 3);
    endcase
    ecrc_fwd_en_i <= 1'(en_req);
    if (stim_q.size() > 0 && (gap_mode == 0 || $urandom_range(0, 3) != 0)) begin
      src_valid_i <= 1'b1;
      {src_sop_i, src_eop_i, src_data_i} <= stim_q[0];
    end else begin
      src_valid_i <= 1'b0;
      {src_sop_i, src_eop_i, src_data_i} <= {2'b00, 64'hDEAD_BEEF_0BAD_F00D};
    end
  end

  task automatic add_pkt(input logic [2:0] fmt, input logic [4:0] typ, input int nbeats, input int id);
    for (int i = 0; i < nbeats; i++) begin
      logic [63:0] d;
      if (i == 0) d = {8'hB0, 8'(id), 16'h0001, fmt, typ, 8'h0F, 1'b1, 15'h0123};
      else        d = {8'hC0, 8'(id), 8'(i), 8'h00, 3'b010, 5'b00100, 8'h00, 1'b1, 15'h7ABC};
      stim_q.push_back({(i == 0), (i == nbeats - 1), d});
    end
  endtask

  task automatic drain();
    rdy_mode = 0;
    while (stim_q.size() > 0 || exp_q.size() > 0) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_test();
  end

  initial begin
    // R1: outputs idle while reset is held with ready high and data waiting
    en_req = 1;
    add_pkt(3'b000, 5'b00100, 2, 1);
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", {63'b0, tx_valid_o, tx_sop_o, tx_eop_o}, 66'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", {65'b0, tx_valid_o}, 66'b0);

    // back-to-back packets with ready steady high (R5, R8)
    add_pkt(3'b010, 5'b00100, 3, 2);
    add_pkt(3'b011, 5'b00000, 4, 3);
    add_pkt(3'b001, 5'b00100, 2, 4);
    add_pkt(3'b000, 5'b00100, 1, 5);
    add_pkt(3'b010, 5'b00101, 2, 6);
    drain();
    checks++;
    if (b2b < 3) begin
      fails++;
      $display("FAIL R5 back-to-back starts actual=%0d expected>=3", b2b);
    end

    // periodic ready with source gaps
    rdy_mode = 3; gap_mode = 1;
    for (int p = 0; p < 12; p++) add_pkt(3'(p % 4), (p % 2) ? 5'b00100 : 5'b00000, 1 + p % 4, 16 + p);
    while (stim_q.size() > 0) @(posedge clk_i);
    drain();

    // forwarding disabled: configuration packets untouched (R9)
    en_req = 0; rdy_mode = 2; gap_mode = 0;
    for (int p = 0; p < 10; p++) add_pkt((p % 2) ? 3'b010 : 3'b000, 5'b00100, 1 + p % 3, 40 + p);
    while (stim_q.size() > 0) @(posedge clk_i);
    drain();

    // long stall with a full buffer, then release (R3, R4, R7)
    en_req = 1; rdy_mode = 1;
    for (int p = 0; p < 4; p++) add_pkt(3'b000, 5'b00100, 2, 60 + p);
    repeat (20) @(posedge clk_i);
    rdy_mode = 2; gap_mode = 1;
    while (stim_q.size() > 0) @(posedge clk_i);
    drain();

    done = 1;
    finish_test();
  end
endmodule